// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Port

An asynchronous serial transmitter and receiver sit behind a byte-wide register bus with two addresses. Address 0 is the control register. Address 1 is the data buffer: a write starts a transmission, and a read returns the last accepted received byte. Frames carry either eight data bits or nine data bits, depending on the mode field. A 16x oversampling enable tick `tick_i` paces both directions. Generating that tick is the job of logic outside this block.

In nine-bit networks, one node addresses another by setting the ninth bit. With the filter bit set, a listener accepts only frames whose ninth bit is 1, so data traffic meant for other nodes never reaches it. In eight-bit mode, the same filter bit drops frames whose stop bit is sampled low. A single interrupt line reports a finished transmission or an accepted reception. Both flags remain set until software clears them.

Control register layout: bit 7 is the receive flag, bit 6 the transmit flag, bit 5 the received ninth bit (read-only), bit 4 the ninth bit to send, bit 3 the receiver enable, bit 2 the filter, and bits 1:0 the mode. Modes 0 and 1 select eight-bit frames; modes 2 and 3 select nine-bit frames.

Top module: `ser9_port`

## Requirements
- R1: After reset, control reads 0x00, data reads 0x00, `txd_o` is 1 and `irq_o` is 0.
- R2: A data write while the transmitter is idle sends a start bit of 0, then the eight data bits LSB first, then the ninth bit in nine-bit modes, then a stop bit of 1. Each bit lasts 16 ticks. A data write while a frame is in progress is ignored.
- R3: The transmit flag (control bit 6) sets when the last data bit of a frame completes, before the stop bit. It stays set until a control write with bit 6 at 0.
- R4: In modes 2 and 3, the ninth transmitted bit equals control bit 4.
- R5: In modes 2 and 3, an accepted frame loads the data buffer and copies its ninth bit into control bit 5. The receive flag (control bit 7) sets after the final sample of the ninth bit.
- R6: In modes 0 and 1 with the filter clear, every frame is accepted, including one with a low stop bit. Control bit 5 takes the stop-bit level.
- R7: With the filter (control bit 2) set, a nine-bit frame whose ninth bit is 0, or an eight-bit frame whose stop bit is 0, is dropped. The receive flag, the data buffer and control bit 5 all keep their values.
- R8: `irq_o` is 1 exactly when the transmit flag or the receive flag is set.
- R9: While control bit 3 is 0, activity on `rxd_i` has no effect.
- R10: Each bit is resolved by majority vote of three samples taken at ticks 7, 8 and 9 of the bit. A start bit that votes high returns the receiver to idle, and the next real frame is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x bit-rate enable |
| addr_i | input | 1 | Register select: 0 control, 1 data |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
Two kinds of internal error are visible at the ports. A wrong transmit bit counter or phase counter shows up within one frame on `txd_o`: a data bit lands in the wrong slot, or a stop or ninth bit goes missing. A wrong receive vote, or a wrong acceptance decision, shows up on the next register read after the frame: the flag, the buffered byte or the ninth bit is wrong. The receiver's resynchronisation state is a special case. After a dropped frame or a false start, it only shows on the following frame, which then arrives shifted by one or more bits.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned C_RXF  = 7;
  localparam int unsigned C_TXF  = 6;
  localparam int unsigned C_RB9  = 5;
  localparam int unsigned C_TB9  = 4;
  localparam int unsigned C_REN  = 3;
  localparam int unsigned C_FILT = 2;

  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_WAIT} rx_state_e;
endpackage

// File: rtl/ser9_sync.sv
module ser9_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ser9_tx.sv
module ser9_tx #(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          nine_i,
  input  logic          b9_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          txd_o
);
  localparam int unsigned FW = DW + 3;
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned IW = $clog2(FW + 1);

  logic [FW-1:0] sr_q;
  logic [CW-1:0] ph_q;
  logic [IW-1:0] idx_q, last_q;
  logic          busy_q, done_q;
  logic          bit_end;

  assign bit_end = busy_q && tick_i && (ph_q == CW'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      ph_q   <= '0;
      idx_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= bit_end && (idx_q == last_q - 1'b1);
      if (start_i && !busy_q) begin
        // stop, ninth (or idle 1), data, start
        sr_q   <= {1'b1, (nine_i ? b9_i : 1'b1), data_i, 1'b0};
        last_q <= nine_i ? IW'(DW + 2) : IW'(DW + 1);
        busy_q <= 1'b1;
        ph_q   <= '0;
        idx_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (bit_end) begin
          ph_q  <= '0;
          sr_q  <= {1'b1, sr_q[FW-1:1]};
          idx_q <= idx_q + 1'b1;
          if (idx_q == last_q) busy_q <= 1'b0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign txd_o  = busy_q ? sr_q[0] : 1'b1;

  // R2
  tx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && !txd_o);
  // R3
  tx_done_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> busy_q && txd_o);
endmodule

// File: rtl/ser9_rx.sv
module ser9_rx
  import ser9_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          rxd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          b9_o
);
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned IW   = $clog2(DW + 2);
  localparam int unsigned MID  = OSR / 2;
  localparam int unsigned LAST = DW + 1;

  rx_state_e     st_q;
  logic [CW-1:0] ph_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] sh_q;
  logic          s0_q, s1_q, b9_q, done_q;
  logic          vote;

  assign vote = (s0_q & s1_q) | (s0_q & rxd_i) | (s1_q & rxd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      s0_q   <= 1'b1;
      s1_q   <= 1'b1;
      b9_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else begin
        unique case (st_q)
          RX_IDLE: if (tick_i && !rxd_i) begin
            st_q  <= RX_RUN;
            ph_q  <= CW'(1);
            idx_q <= '0;
          end
          RX_RUN: if (tick_i) begin
            if (ph_q == CW'(OSR - 1)) begin
              ph_q  <= '0;
              idx_q <= idx_q + 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
            if (ph_q == CW'(MID - 1)) s0_q <= rxd_i;
            if (ph_q == CW'(MID))     s1_q <= rxd_i;
            if (ph_q == CW'(MID + 1)) begin
              if (idx_q == '0) begin
                if (vote) st_q <= RX_IDLE;  // false start
              end else if (idx_q == IW'(LAST)) begin
                done_q <= 1'b1;
                b9_q   <= vote;
                st_q   <= RX_WAIT;
              end else begin
                sh_q <= {vote, sh_q[DW-1:1]};
              end
            end
          end
          RX_WAIT: if (rxd_i) st_q <= RX_IDLE;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;
  assign b9_o   = b9_q;

  // R9
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> st_q == RX_IDLE && !done_q);
  // R5
  rx_done_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> st_q == RX_WAIT);
endmodule

// File: rtl/ser9_port.sv
module ser9_port
  import ser9_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              addr_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_o
);
  logic [1:0]        mode_q;
  logic              filt_q, ren_q, tb9_q, rb9_q, txf_q, rxf_q;
  logic [BYTE_W-1:0] rx_buf_q;
  logic              rxd_s, tx_busy, tx_done, rx_done, rx_b9, accept;
  logic              ctrl_we, data_we;
  logic [BYTE_W-1:0] rx_data;

  assign ctrl_we = we_i && !addr_i;
  assign data_we = we_i && addr_i;
  assign accept  = rx_done && (!filt_q || rx_b9);

  ser9_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  ser9_tx #(.OSR(OSR), .DW(BYTE_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .start_i(data_we),
    .nine_i (mode_q[1]),
    .b9_i   (tb9_q),
    .data_i (wdata_i),
    .busy_o (tx_busy),
    .done_o (tx_done),
    .txd_o  (txd_o)
  );

  ser9_rx #(.OSR(OSR), .DW(BYTE_W)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .en_i  (ren_q),
    .rxd_i (rxd_s),
    .done_o(rx_done),
    .data_o(rx_data),
    .b9_o  (rx_b9)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      filt_q   <= 1'b0;
      ren_q    <= 1'b0;
      tb9_q    <= 1'b0;
      rb9_q    <= 1'b0;
      txf_q    <= 1'b0;
      rxf_q    <= 1'b0;
      rx_buf_q <= '0;
    end else begin
      if (ctrl_we) begin
        mode_q <= wdata_i[1:0];
        filt_q <= wdata_i[C_FILT];
        ren_q  <= wdata_i[C_REN];
        tb9_q  <= wdata_i[C_TB9];
        txf_q  <= wdata_i[C_TXF];
        rxf_q  <= wdata_i[C_RXF];
      end
      // hardware set wins over a same-cycle software clear
      if (tx_done) txf_q <= 1'b1;
      if (accept) begin
        rxf_q    <= 1'b1;
        rx_buf_q <= rx_data;
        rb9_q    <= rx_b9;
      end
    end
  end

  assign rdata_o = addr_i ? rx_buf_q
                          : {rxf_q, txf_q, rb9_q, tb9_q, ren_q, filt_q, mode_q};
  assign irq_o   = txf_q | rxf_q;

  // R3
  txf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done |=> txf_q);
  // R5
  rxf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rxf_q && rx_buf_q == $past(rx_data));
  // R7
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done && filt_q && !rx_b9 |=> $stable(rx_buf_q) && $stable(rb9_q));
  // R2
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy && !tx_done && !ctrl_we |=> $stable(txf_q));
endmodule

// File: tb/test_ser9_port.sv
module test_ser9_port;
  localparam int BIT = 32;  // 16 ticks, tick every other clock

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       addr = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, irq;

  int checks = 0;
  int errors = 0;
  int tx_frames = 0;
  bit finished = 0;

  typedef struct {logic [7:0] d; logic b9; logic nine;} txexp_t;
  txexp_t txq[$];

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  ser9_port i_ser9_port (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic send(input logic [7:0] d, input logic nine, input logic b9);
    txexp_t e;
    e.d = d; e.b9 = b9; e.nine = nine;
    txq.push_back(e);
    wr(1'b1, d);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic nine, input logic b9,
                          input logic stopv);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (nine) begin
      rxd = b9;
      repeat (BIT) @(negedge clk);
    end
    rxd = stopv;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  // monitor: decode frames on txd and compare with the queue
  initial begin
    txexp_t e;
    logic [8:0] got;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (BIT / 2) @(negedge clk);
        got = '0;
        if (txq.size() == 0) begin
          chk("R2 unexpected frame", 9'h1, 9'h0);
        end else begin
          e = txq.pop_front();
          for (int i = 0; i < (e.nine ? 9 : 8); i++) begin
            repeat (BIT) @(negedge clk);
            got[i] = txd;
          end
          repeat (BIT) @(negedge clk);
          chk("R2 tx data", {1'b0, got[7:0]}, {1'b0, e.d});
          if (e.nine) chk("R4 tx ninth", {8'h0, got[8]}, {8'h0, e.b9});
          chk("R2 tx stop", {8'h0, txd}, 9'h1);
          tx_frames++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, v); chk("R1 ctrl", {1'b0, v}, 9'h00);
    rd(1'b1, v); chk("R1 data", {1'b0, v}, 9'h00);
    chk("R1 txd", {8'h0, txd}, 9'h1);
    chk("R1 irq", {8'h0, irq}, 9'h0);

    // eight-bit transmit, busy write ignored, flag timing
    wr(1'b0, 8'h09);
    send(8'hA5, 1'b0, 1'b0);
    wr(1'b1, 8'h3C);
    repeat (9 * BIT - BIT / 2 - 2) @(negedge clk);
    rd(1'b0, v); chk("R3 txf before last bit ends", {8'h0, v[6]}, 9'h0);
    repeat (BIT) @(negedge clk);
    rd(1'b0, v); chk("R3 txf after last bit", {8'h0, v[6]}, 9'h1);
    chk("R8 irq on txf", {8'h0, irq}, 9'h1);
    repeat (4 * BIT) @(negedge clk);
    rd(1'b0, v); chk("R3 txf sticky", {8'h0, v[6]}, 9'h1);
    chk("R2 one frame only", 9'(tx_frames), 9'd1);
    wr(1'b0, 8'h09);
    rd(1'b0, v); chk("R3 txf cleared", {8'h0, v[6]}, 9'h0);
    chk("R8 irq clear", {8'h0, irq}, 9'h0);

    // nine-bit transmits
    wr(1'b0, 8'h1A);
    send(8'h5A, 1'b1, 1'b1);
    repeat (13 * BIT) @(negedge clk);
    wr(1'b0, 8'h0B);
    send(8'hC3, 1'b1, 1'b0);
    repeat (13 * BIT) @(negedge clk);
    chk("R4 frames sent", 9'(tx_frames), 9'd3);

    // receive, eight-bit, filter clear
    wr(1'b0, 8'h09);
    rx_frame(8'h96, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R6 rxf good stop", {8'h0, v[7]}, 9'h1);
    chk("R6 rb9 stop high", {8'h0, v[5]}, 9'h1);
    rd(1'b1, v); chk("R6 data", {1'b0, v}, 9'h096);
    wr(1'b0, 8'h09);
    rx_frame(8'h4B, 1'b0, 1'b0, 1'b0);
    rd(1'b0, v); chk("R6 rxf bad stop accepted", {8'h0, v[7]}, 9'h1);
    chk("R6 rb9 stop low", {8'h0, v[5]}, 9'h0);
    rd(1'b1, v); chk("R6 data bad stop", {1'b0, v}, 9'h04B);

    // filter set, eight-bit
    wr(1'b0, 8'h0D);
    rx_frame(8'h11, 1'b0, 1'b0, 1'b0);
    rd(1'b0, v); chk("R7 rxf dropped", {8'h0, v[7]}, 9'h0);
    chk("R7 rb9 kept", {8'h0, v[5]}, 9'h0);
    rd(1'b1, v); chk("R7 data kept", {1'b0, v}, 9'h04B);
    rx_frame(8'h22, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R7 good stop passes", {8'h0, v[7]}, 9'h1);
    rd(1'b1, v); chk("R7 data passes", {1'b0, v}, 9'h022);

    // filter set, nine-bit
    wr(1'b0, 8'h0E);
    rx_frame(8'h33, 1'b1, 1'b0, 1'b1);
    rd(1'b0, v); chk("R7 ninth 0 dropped", {8'h0, v[7]}, 9'h0);
    chk("R7 rb9 kept", {8'h0, v[5]}, 9'h1);
    rd(1'b1, v); chk("R7 data kept", {1'b0, v}, 9'h022);
    rx_frame(8'h44, 1'b1, 1'b1, 1'b1);
    rd(1'b0, v); chk("R5 rxf ninth 1", {8'h0, v[7]}, 9'h1);
    chk("R5 rb9", {8'h0, v[5]}, 9'h1);
    chk("R8 irq on rxf", {8'h0, irq}, 9'h1);
    rd(1'b1, v); chk("R5 data", {1'b0, v}, 9'h044);

    // nine-bit, filter clear, ninth 0 accepted
    wr(1'b0, 8'h0B);
    rx_frame(8'h55, 1'b1, 1'b0, 1'b1);
    rd(1'b0, v); chk("R5 rxf ninth 0", {8'h0, v[7]}, 9'h1);
    chk("R5 rb9 zero", {8'h0, v[5]}, 9'h0);
    rd(1'b1, v); chk("R5 data", {1'b0, v}, 9'h055);

    // receiver disabled
    wr(1'b0, 8'h03);
    rx_frame(8'h66, 1'b1, 1'b1, 1'b1);
    rd(1'b0, v); chk("R9 rxf off", {8'h0, v[7]}, 9'h0);
    rd(1'b1, v); chk("R9 data kept", {1'b0, v}, 9'h055);

    // false start then a real frame
    wr(1'b0, 8'h0B);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    rd(1'b0, v); chk("R10 false start", {8'h0, v[7]}, 9'h0);
    rx_frame(8'h77, 1'b1, 1'b1, 1'b1);
    rd(1'b0, v); chk("R10 rxf after glitch", {8'h0, v[7]}, 9'h1);
    rd(1'b1, v); chk("R10 data after glitch", {1'b0, v}, 9'h077);

    wr(1'b0, 8'h00);
    chk("R8 irq cleared", {8'h0, irq}, 9'h0);
    chk("R2 tx queue drained", 9'(txq.size()), 9'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule